// File: doc/BRIEF.md
# Time-Domain Equalizer FIR

This block is a programmable finite-impulse-response equalizer for a multitone receiver. Each accepted 16-bit two's-complement sample enters a delay line. The block then forms the dot product of the newest TAPS samples with TAPS signed 13-bit coefficients, using one multiply-accumulate per clock into a 35-bit accumulator. A DC compensation term, aligned to the accumulator's binary point, is added to the sum. The result is scaled by a power-of-two gain, rounded to nearest and clamped to a 20-bit word.

The coefficients sit in two banks. One bank feeds the multiplier. The other is open to the write port, so software can prepare the next filter while the current one keeps running. A symbol-boundary strobe exchanges the two banks, and the exchange never happens in the middle of an output computation. When a result had to be clamped, a one-cycle pulse comes out with it, and a sticky flag stays set for the front-end gain control until it is cleared.

Top module: `tdeq_fir`

## Requirements
- R1: After reset, `y` is 0, `y_valid`, `sat_pulse` and `sat_flag` are 0, and every coefficient in both banks and every delay-line entry is 0. A sample filtered before any coefficient write therefore yields 0.
- R2: A sample is accepted on a rising edge where `smp_valid` is 1 and no computation is in progress. Exactly TAPS+1 edges later, `y_valid` is high for one cycle. At that point `y` carries the filtered value of sum over k of c[k]*x[n-k] for k = 0..TAPS-1, where x[n] is the accepted sample, x[n-k] is the sample accepted k acceptances earlier, and c[k] is entry k of the active bank.
- R3: A `smp_valid` raised while a computation is in progress is ignored. That sample never enters the delay line.
- R4: `dc_ofs` (signed 16-bit) is captured at acceptance and added to the accumulator as dc_ofs * 2^(CW-1), which is 2^12 by default.
- R5: `gain` is captured at acceptance. The effective gain is G = min(gain, MAXG), and the accumulator is divided by 2^(BASE_SH-G). With the defaults BASE_SH = 9 and MAXG = 7, a gain code from 8 to 15 acts as 7. When the shift is nonzero, 2^(shift-1) is added before the arithmetic right shift (round to nearest, ties upward).
- R6: A scaled value above 524287 gives `y` = 524287, and one below -524288 gives `y` = -524288.
- R7: `sat_pulse` is 1 exactly in the `y_valid` cycle of an output that was clamped. It is 0 otherwise.
- R8: `sat_flag` sets with a clamped output and holds, through unclamped outputs, until `sat_clr` is 1 on a clock edge. A clamp on that same edge wins.
- R9: A write with `cw_en` = 1 stores `cw_data` at index `cw_addr` (tap k multiplies x[n-k]) of the bank not currently active. Such a write does not change the outputs produced from the active bank.
- R10: A `sym_edge` seen while idle exchanges the banks on that edge. One or more strobes seen during a computation cause a single exchange once the block returns to idle, so the running output and every product of it use the old bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW | Signed input sample |
| sym_edge | input | 1 | Symbol-boundary strobe requesting a bank exchange |
| cw_en | input | 1 | Coefficient write enable |
| cw_addr | input | log2(TAPS) | Tap index of the write |
| cw_data | input | CW | Signed coefficient value |
| gain | input | GW | Gain code in 6 dB steps |
| dc_ofs | input | DW | Signed DC compensation value |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| y | output | OW | Scaled, rounded, clamped result |
| y_valid | output | 1 | One-cycle result strobe |
| sat_pulse | output | 1 | Result in this cycle was clamped |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench runs an eight-tap configuration and works out every expected output with exact integer arithmetic. An impulse walked across the delay line exposes each coefficient in its own output, which separates a tap-order or delay-line fault from an arithmetic one. A gain sweep over all sixteen codes with odd sums tells rounding errors, off-by-one shifts and a missing clamp of the code apart. Offset values at both extremes check the alignment of the compensation term. Full-scale inputs of both signs drive both clamp directions and the flag behaviour. Pseudo-random samples, spurious strobes during a computation and boundary strobes with staged banks show which bank and which samples a result was built from.

// File: rtl/tdeq_fir.sv
module tdeq_fir #(
  parameter int TAPS    = 64,
  parameter int DW      = 16,
  parameter int CW      = 13,
  parameter int OW      = 20,
  parameter int ACCW    = 35,
  parameter int GW      = 4,
  parameter int MAXG    = 7,
  parameter int BASE_SH = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        smp_valid,
  input  logic signed [DW-1:0]        smp_data,
  input  logic                        sym_edge,
  input  logic                        cw_en,
  input  logic [$clog2(TAPS)-1:0]     cw_addr,
  input  logic signed [CW-1:0]        cw_data,
  input  logic [GW-1:0]               gain,
  input  logic signed [DW-1:0]        dc_ofs,
  input  logic                        sat_clr,
  output logic signed [OW-1:0]        y,
  output logic                        y_valid,
  output logic                        sat_pulse,
  output logic                        sat_flag
);
  localparam int AW = $clog2(TAPS);
  localparam int PW = DW + CW;

  typedef enum logic [1:0] {IDLE, RUN, FIN} st_t;

  st_t                  st;
  logic signed [CW-1:0] cb [2][TAPS];
  logic signed [DW-1:0] dl [TAPS];
  logic                 act, pend;
  logic [AW-1:0]        k;
  logic signed [ACCW-1:0] acc;
  logic [GW-1:0]        g_q;

  wire idle = (st == IDLE);
  wire flip = idle && (sym_edge || pend);

  logic signed [CW-1:0] c_cur;
  logic signed [DW-1:0] x_cur;
  logic signed [PW-1:0] prod;
  assign c_cur = cb[act][k];
  assign x_cur = dl[k];
  assign prod  = {{DW{c_cur[CW-1]}}, c_cur} * {{CW{x_cur[DW-1]}}, x_cur};

  wire signed [ACCW-1:0] ofs_s = {{(ACCW-DW-CW+1){dc_ofs[DW-1]}}, dc_ofs, {(CW-1){1'b0}}};
  wire signed [ACCW-1:0] prod_x = {{(ACCW-PW){prod[PW-1]}}, prod};

  logic signed [ACCW:0] rnd, sum_r, shd;
  logic                 ovf;
  logic signed [OW-1:0] ysat;
  int                   geff, rsh;

  always_comb begin
    geff = (int'(g_q) > MAXG) ? MAXG : int'(g_q);
    rsh  = BASE_SH - geff;
    rnd  = '0;
    if (rsh > 0) rnd[rsh-1] = 1'b1;
    sum_r = {acc[ACCW-1], acc} + rnd;
    shd   = sum_r >>> rsh;
  end

  assign ovf  = !((&shd[ACCW:OW-1]) || !(|shd[ACCW:OW-1]));
  assign ysat = shd[ACCW] ? {1'b1, {(OW-1){1'b0}}} : {1'b0, {(OW-1){1'b1}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      act       <= 1'b0;
      pend      <= 1'b0;
      k         <= '0;
      acc       <= '0;
      g_q       <= '0;
      y         <= '0;
      y_valid   <= 1'b0;
      sat_pulse <= 1'b0;
      sat_flag  <= 1'b0;
      for (int i = 0; i < TAPS; i++) begin
        dl[i]    <= '0;
        cb[0][i] <= '0;
        cb[1][i] <= '0;
      end
    end else begin
      y_valid   <= 1'b0;
      sat_pulse <= 1'b0;
      if (flip) act <= ~act;
      pend <= idle ? 1'b0 : (pend || sym_edge);
      if (cw_en) cb[!act][cw_addr] <= cw_data;
      if (sat_clr) sat_flag <= 1'b0;
      case (st)
        IDLE: if (smp_valid) begin
          for (int i = TAPS - 1; i > 0; i--) dl[i] <= dl[i-1];
          dl[0] <= smp_data;
          acc   <= ofs_s;
          g_q   <= gain;
          k     <= '0;
          st    <= RUN;
        end
        RUN: begin
          acc <= acc + prod_x;
          k   <= k + 1'b1;
          if (k == AW'(TAPS - 1)) st <= FIN;
        end
        default: begin
          y         <= ovf ? ysat : shd[OW-1:0];
          y_valid   <= 1'b1;
          sat_pulse <= ovf;
          if (ovf) sat_flag <= 1'b1;
          st        <= IDLE;
        end
      endcase
    end
  end

  // R2
  y_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |=> !y_valid);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != IDLE) |=> $stable(dl[0]));

  // R7
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_pulse |-> y_valid && (y[OW-1] ? (y[OW-2:0] == '0) : (&y[OW-2:0])));

  // R8
  sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag);

  // R8
  sat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_pulse |-> sat_flag);

  // R10
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RUN) |=> $stable(act));
endmodule

// File: tb/test_tdeq_fir.sv
`timescale 1ns/1ps
module test_tdeq_fir;
  localparam int T = 8;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, sym_edge = 0, cw_en = 0, sat_clr = 0;
  logic signed [15:0] smp_data = 0, dc_ofs = 0;
  logic [2:0] cw_addr = 0;
  logic signed [12:0] cw_data = 0;
  logic [3:0] gain = 0;
  logic signed [19:0] y;
  logic y_valid, sat_pulse, sat_flag;

  tdeq_fir #(.TAPS(T)) i_tdeq_fir (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .sym_edge(sym_edge), .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
    .gain(gain), .dc_ofs(dc_ofs), .sat_clr(sat_clr),
    .y(y), .y_valid(y_valid), .sat_pulse(sat_pulse), .sat_flag(sat_flag));

  always #4 clk = ~clk;

  int ng = 0, nf = 0;
  int hist [T];
  int mb [2][T];
  int mact = 0;
  bit mflag = 0;
  int seed = 7;

  task automatic chk(input bit ok, input string tag, input longint a, input longint e);
    ng++;
    if (!ok) begin
      nf++;
      $display("FAIL %s: got %0d expected %0d", tag, a, e);
    end
  endtask

  function automatic longint model(input int ofs, input int g, output bit sat);
    longint acc = longint'(ofs) * 4096;
    int ge, rsh;
    for (int k = 0; k < T; k++) acc += longint'(mb[mact][k]) * longint'(hist[k]);
    ge  = (g > 7) ? 7 : g;
    rsh = 9 - ge;
    if (rsh > 0) acc = (acc + (64'sd1 <<< (rsh - 1))) >>> rsh;
    sat = 1'b1;
    if (acc > 524287) return 524287;
    if (acc < -524288) return -524288;
    sat = 1'b0;
    return acc;
  endfunction

  task automatic wr(input int a, input int v);
    @(negedge clk); cw_en = 1; cw_addr = 3'(a); cw_data = 13'(v);
    @(negedge clk); cw_en = 0;
    mb[1 - mact][a] = v;
  endtask

  task automatic swap_idle();
    @(negedge clk); sym_edge = 1;
    @(negedge clk); sym_edge = 0;
    mact = 1 - mact;
  endtask

  task automatic clr();
    @(negedge clk); sat_clr = 1;
    @(negedge clk); sat_clr = 0;
    mflag = 0;
    chk(sat_flag == 0, "R8 clear", sat_flag, 0);
  endtask

  task automatic run(input int x, input int g, input int ofs, input bit extra,
                     input int nstb, input string tag);
    longint e; bit es; int cnt = 0;
    @(negedge clk); smp_data = 16'(x); smp_valid = 1; gain = 4'(g); dc_ofs = 16'(ofs);
    @(negedge clk); smp_valid = 0;
    for (int i = T - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    e = model(ofs, g, es);
    while (cnt < 40) begin
      @(negedge clk); cnt++;
      smp_valid = extra && (cnt == 2);
      if (cnt == 2) smp_data = 16'h5a5a;
      sym_edge = (cnt >= 4) && (cnt < 4 + nstb);
      if (y_valid) break;
    end
    smp_valid = 0; sym_edge = 0;
    chk(cnt == T + 1, {"R2 latency ", tag}, cnt, T + 1);
    chk(y == e, tag, y, e);
    chk(sat_pulse == es, "R7 pulse", sat_pulse, es);
    if (es) mflag = 1;
    chk(sat_flag == mflag, "R8 flag", sat_flag, mflag);
    if (nstb > 0) mact = 1 - mact;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nf++; ng++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", ng - nf, ng);
    $finish;
  end

  initial begin
    for (int i = 0; i < T; i++) begin hist[i] = 0; mb[0][i] = 0; mb[1][i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(y == 0 && y_valid == 0 && sat_pulse == 0, "R1 outputs", y, 0);
    chk(sat_flag == 0, "R1 flag", sat_flag, 0);
    rst_n = 1;
    run(12345, 7, 0, 0, 0, "R1 zero banks");
    // R9 writes land in inactive bank
    for (int k = 0; k < T; k++) wr(k, ((k % 2) ? -1 : 1) * (311 * (k + 1) + 17));
    run(-20000, 7, 0, 0, 0, "R9 inactive bank untouched");
    swap_idle();
    // R2 impulse walk
    run(4096, 0, 0, 0, 0, "R2 impulse");
    for (int k = 1; k < T; k++) run(0, 0, 0, 0, 0, "R2 impulse walk");
    // R5 gain sweep with clamp of codes 8..15
    for (int g = 0; g < 16; g++) run(3001 - 517 * g, g, 0, 0, 0, "R5 gain");
    // R4 offsets
    run(0, 3, -32768, 0, 0, "R4 offset min");
    run(5, 3, -1, 0, 0, "R4 offset -1");
    run(-7, 5, 1, 0, 0, "R4 offset 1");
    run(1111, 2, 777, 0, 0, "R4 offset 777");
    run(-3, 0, 32767, 0, 0, "R4 offset max");
    // R3 spurious sample during computation
    run(2222, 4, 0, 1, 0, "R3 ignored sample");
    run(-3333, 4, 0, 0, 0, "R3 history intact");
    // R10 deferred swap: new bank staged, strobes during busy
    for (int k = 0; k < T; k++) wr(k, 4095 - 1000 * (k % 3));
    run(777, 6, 0, 0, 3, "R10 old bank kept");
    run(-777, 6, 0, 0, 0, "R10 single swap");
    // R6 saturation both ways
    for (int k = 0; k < T; k++) wr(k, 4095);
    swap_idle();
    for (int i = 0; i < T; i++) run(32767, 7, 32767, 0, 0, "R6 positive clamp");
    run(100, 0, 0, 0, 0, "R8 sticky through unclamped");
    for (int i = 0; i < T; i++) run(-32768, 7, -32768, 0, 0, "R6 negative clamp");
    clr();
    for (int i = 0; i < T; i++) run(0, 0, 0, 0, 0, "R7 no pulse");
    // R2 pseudo-random traffic
    for (int k = 0; k < T; k++) wr(k, ((k * 1237 + 91) % 8192) - 4096);
    swap_idle();
    for (int i = 0; i < 40; i++) begin
      seed = seed * 1103515245 + 12345;
      run(int'(shortint'(seed >>> 8)), i % 10, (i % 3 == 0) ? (i * 331 - 6000) : 0, 0, 0, "R2 random");
    end
    $display("%0d/%0d checks passed", ng - nf, ng);
    $finish;
  end
endmodule